// File: doc/BRIEF.md
# Select-Driven Multifunction Register

This block is a single register of parameterised width. A four-way multiplexer picks its next value on every rising clock edge. An outside controller drives a 2-bit operation code. The code picks one of four candidates: the present contents, a parallel input word, the contents plus one, or the contents moved one place toward the least significant end.

The register has no enable of any kind. It captures a value on every edge, and keeping the present value is just one more multiplexer input. A registered wrap flag goes with the increment path. The output and the flag come straight from flip-flops, so a change on the select or data pins is only seen at the next edge.

The operation codes are treated as the named states of the datapath:
- `OP_KEEP` (00) keeps the present value.
- `OP_LOAD` (01) takes in the input word.
- `OP_INC` (10) adds one.
- `OP_SHR` (11) shifts right.

Any code may follow any other code on the next edge. The reset transition overrides all of them and forces the register to zero.

Top module: `mfreg_top`

## Requirements
- R1: With operation code 00 (`OP_KEEP`) at an edge, the output keeps its previous value, and the data input has no effect.
- R2: With operation code 01 (`OP_LOAD`) at an edge, the output takes the value the data input had at that edge.
- R3: With operation code 10 (`OP_INC`) at an edge, the output becomes the previous value plus one, modulo 2^W, so all ones wraps to zero.
- R4: With operation code 11 (`OP_SHR`) at an edge, the output becomes the previous value shifted right by one place. Bit W-1 fills with zero and the old bit 0 is lost.
- R5: The wrap flag is high for exactly the one cycle after an edge at which code 10 was applied to an all-ones value. At every other time it is low.
- R6: When the synchronous active-high reset is high at an edge, the output and the wrap flag become zero, whatever the operation code and data input are.
- R7: The output and the wrap flag change only at a rising clock edge. A change on the operation code or the data input between edges has no effect until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | Operation code: 00 keep, 01 load, 10 increment, 11 shift right |
| din | input | W | Parallel word for the load operation |
| q | output | W | Registered contents |
| wrap_o | output | 1 | Registered flag, high for one cycle after an increment wraps |

## Verification
Two pairs of events can fall on the same edge.
- Reset and an active operation: the bench holds reset high while it presents a load of all ones and, in a second case, an increment of an all-ones value. It then checks that the output and the wrap flag are zero after the edge.
- The increment wrap and the flag: the bench steps the register from 0xFE through 0xFF to 0x00. It checks that the flag rises only with the zero value and falls again on the following hold.

// File: rtl/mfreg_pkg.sv
package mfreg_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_LOAD = 2'b01,
        OP_INC  = 2'b10,
        OP_SHR  = 2'b11
    } op_e;

endpackage

// File: rtl/mfreg_srcgen.sv
module mfreg_srcgen #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] inc_val,
    output logic         inc_wrap,
    output logic [W-1:0] shr_val
);

    localparam logic [W:0] ONE_EXT = (W+1)'(1);

    logic [W:0] sum_ext;

    always_comb begin
        sum_ext  = {1'b0, cur} + ONE_EXT;
        inc_val  = sum_ext[W-1:0];
        inc_wrap = sum_ext[W];
        shr_val  = cur >> 1;
    end

    // Wrap is only reported when the present value is all ones
    always_comb begin
        AST_WRAP_SRC: assert (inc_wrap == (&cur)); // R5
    end

endmodule

// File: rtl/mfreg_mux.sv
module mfreg_mux
    import mfreg_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          sel,
    input  logic [W-1:0] src_keep,
    input  logic [W-1:0] src_load,
    input  logic [W-1:0] src_inc,
    input  logic [W-1:0] src_shr,
    input  logic         inc_wrap,
    output logic [W-1:0] y,
    output logic         wrap_nxt
);

    always_comb begin
        wrap_nxt = 1'b0;
        unique case (sel)
            OP_KEEP: y = src_keep;
            OP_LOAD: y = src_load;
            OP_INC: begin
                y        = src_inc;
                wrap_nxt = inc_wrap;
            end
            OP_SHR:  y = src_shr;
            default: y = src_keep;
        endcase
    end

endmodule

// File: rtl/mfreg_top.sv
module mfreg_top
    import mfreg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         wrap_o
);

    localparam logic [W-1:0] ZERO = '0;

    op_e          op;
    logic [W-1:0] inc_val;
    logic [W-1:0] shr_val;
    logic         inc_wrap;
    logic [W-1:0] q_nxt;
    logic         wrap_nxt;

    assign op = op_e'(op_sel);

    mfreg_srcgen #(.W(W)) srcgen_i (
        .cur      (q),
        .inc_val  (inc_val),
        .inc_wrap (inc_wrap),
        .shr_val  (shr_val)
    );

    mfreg_mux #(.W(W)) mux_i (
        .sel      (op),
        .src_keep (q),
        .src_load (din),
        .src_inc  (inc_val),
        .src_shr  (shr_val),
        .inc_wrap (inc_wrap),
        .y        (q_nxt),
        .wrap_nxt (wrap_nxt)
    );

    // Contents register: captures on every edge
    always_ff @(posedge clk) begin
        if (rst) q <= ZERO;
        else     q <= q_nxt;
    end

    // Flag register
    always_ff @(posedge clk) begin
        if (rst) wrap_o <= 1'b0;
        else     wrap_o <= wrap_nxt;
    end

    AST_KEEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b00) |=> $stable(q)); // R1
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b01) |=> (q == $past(din))); // R2
    AST_INC_ADDS: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b10) |=> (q == W'($past(q) + 1'b1))); // R3
    AST_SHR_MOVES: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b11) |=> (q == ($past(q) >> 1))); // R4
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (q == ZERO)); // R5
    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> !wrap_o || ($past(op_sel) == 2'b10)); // R5
    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> (q == ZERO) && !wrap_o); // R6

endmodule

// File: tb/mfreg_top_tb_top.sv
module mfreg_top_tb_top;

    localparam int W      = 8;
    localparam int NVEC   = 14;
    localparam int VW     = 2 + W + W + 1;
    localparam int TMAX   = 200000;

    // Each entry holds {op, din, expected q, expected flag}
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {2'b01, 8'hA5, 8'hA5, 1'b0},  // R2 load
        {2'b00, 8'h3C, 8'hA5, 1'b0},  // R1 keep, din ignored
        {2'b11, 8'hFF, 8'h52, 1'b0},  // R4 shift, lsb dropped
        {2'b10, 8'h00, 8'h53, 1'b0},  // R3 increment
        {2'b01, 8'hFE, 8'hFE, 1'b0},  // R2
        {2'b10, 8'h11, 8'hFF, 1'b0},  // R3 no wrap
        {2'b10, 8'h22, 8'h00, 1'b1},  // R3 wrap, R5 flag
        {2'b00, 8'h77, 8'h00, 1'b0},  // R5 flag drops
        {2'b11, 8'h00, 8'h00, 1'b0},  // R4 zero stays zero
        {2'b01, 8'h01, 8'h01, 1'b0},  // R2
        {2'b11, 8'hFF, 8'h00, 1'b0},  // R4 lsb discarded
        {2'b01, 8'h80, 8'h80, 1'b0},  // R2
        {2'b11, 8'h00, 8'h40, 1'b0},  // R4 msb fills zero
        {2'b10, 8'h00, 8'h41, 1'b0}   // R3
    };

    logic         clk = 1'b0;
    logic         rst;
    logic [1:0]   op_sel;
    logic [W-1:0] din;
    logic [W-1:0] q;
    logic         wrap_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    mfreg_top #(.W(W)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .op_sel (op_sel),
        .din    (din),
        .q      (q),
        .wrap_o (wrap_o)
    );

    task automatic check(input string req, input logic [W-1:0] eq, input logic ec);
        n_chk++;
        if (q !== eq || wrap_o !== ec) begin
            n_fail++;
            $display("FAIL %s: q=%h wrap=%b expected q=%h wrap=%b", req, q, wrap_o, eq, ec);
        end
    endtask

    // Apply inputs after a falling edge, then sample at the next falling edge
    task automatic step(input logic r, input logic [1:0] s, input logic [W-1:0] d);
        rst    = r;
        op_sel = s;
        din    = d;
        @(negedge clk);
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; op_sel = 2'b01; din = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        check("R6 reset state", 8'h00, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            step(1'b0, VEC[i][VW-1 -: 2], VEC[i][VW-3 -: W]);
            check($sformatf("vector %0d (R1-R5 table)", i), VEC[i][W:1], VEC[i][0]);
        end

        // R7: changing inputs between edges leaves the outputs untouched
        op_sel = 2'b01; din = 8'hC3;
        #1;
        check("R7 no path before edge", 8'h41, 1'b0);
        @(negedge clk);
        check("R7 takes effect at edge", 8'hC3, 1'b0);

        // R6: reset wins over a load of all ones
        step(1'b1, 2'b01, 8'hFF);
        check("R6 reset over load", 8'h00, 1'b0);

        // R6: reset wins over an increment that would wrap
        step(1'b0, 2'b01, 8'hFF);
        check("R2 setup all ones", 8'hFF, 1'b0);
        step(1'b1, 2'b10, 8'h00);
        check("R6 reset over wrap", 8'h00, 1'b0);

        // R5: flag pulse lasts one cycle even with back-to-back increments
        step(1'b0, 2'b01, 8'hFF);
        step(1'b0, 2'b10, 8'h00);
        check("R5 wrap pulse", 8'h00, 1'b1);
        step(1'b0, 2'b10, 8'h00);
        check("R5 pulse ends on next increment", 8'h01, 1'b0);

        // R1: keep over several edges with changing data
        step(1'b0, 2'b00, 8'hAA);
        step(1'b0, 2'b00, 8'h55);
        check("R1 keep multi-cycle", 8'h01, 1'b0);

        report();
    end

    initial begin
        #(TMAX * 4);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

endmodule